// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Capture Sequencer

This block runs an external multi-channel ADC that samples all of its inputs at the same instant. After reset it pulses the converter's reset line. On each conversion request it raises the conversion-start line and waits for the converter's busy line to fall. It then fetches one signed 16-bit word per channel through a strobe/valid read handshake and publishes the whole frame on a wide output bus, together with a one-cycle completion pulse.

The block can also check frame alignment on the converter's first-channel flag. When the check is on and the flag is low at the first word, the frame is dropped, an error pulse is raised and the converter is reset again. The block also drives the oversampling-select pins and the input-range pin from validated configuration writes. It runs ordered sequences to put the converter into standby and to bring it back out. If busy never falls, a timeout ends the conversion with an error.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst` is high and straight after it, `adc_convst` is 0, `stby_n` is 1, `os_sel` is 0 and `range_pin` is 0 (±5 V). A reset pulse follows.
- R2: Every pulse on `adc_reset` lasts exactly RST_CYC clock cycles. A pulse is issued after `rst`, after an alignment failure and after standby exit.
- R3: A `conv_req` in the idle state raises `adc_convst`. No `rd_strobe` is issued until `adc_busy` has been seen to go from 1 to 0.
- R4: `ch_mode` selects how many words are read per frame: 2'b00 reads NCH (8), 2'b01 reads 3·NCH/4 (6), 2'b10 and 2'b11 read NCH/2 (4). Channel k is placed at `frame_data[16k+15:16k]`, and channels that were not read are zero. `frame_done` pulses once per completed frame.
- R5: Stored words are the exact 16-bit values returned, including negative two's-complement values.
- R6: With `align_en`=1, if `adc_frst` is 0 when the first word arrives, the block does the following. It reads no further words, pulses `frame_err` instead of `frame_done`, leaves `frame_data` unchanged and issues a reset pulse. With `align_en`=0 the flag is ignored.
- R7: If busy does not fall within TMO_CYC cycles after conversion start, `frame_err` pulses and no word is read.
- R8: `adc_convst` is 0 in the cycle in which `frame_done` or `frame_err` pulses.
- R9: An `os_wr` with a ratio of 1, 2, 4, 8, 16, 32 or 64 sets `os_sel` to log2 of the ratio (0..6, bit 0 on `os_sel[0]`). Any other ratio leaves `os_sel` unchanged.
- R10: A `range_wr` of 10000 sets `range_pin` to 1 and 5000 sets it to 0. Any other value leaves the pin unchanged.
- R11: `stby_enter` drives `range_pin` high at least one cycle before `stby_n` falls.
- R12: `stby_exit` first restores `range_pin` from the stored range, then raises `stby_n`, then issues a reset pulse.
- R13: Configuration writes and conversion requests made in standby are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Conversion request pulse |
| ch_mode | input | 2 | Channels per frame select |
| align_en | input | 1 | Enable first-channel flag check |
| os_wr | input | 1 | Oversampling write strobe |
| os_ratio | input | 7 | Requested oversampling ratio |
| range_wr | input | 1 | Range write strobe |
| range_mv | input | 14 | Requested range in millivolts |
| stby_enter | input | 1 | Standby entry request |
| stby_exit | input | 1 | Standby exit request |
| adc_busy | input | 1 | Converter busy |
| adc_frst | input | 1 | Converter first-channel flag |
| rd_valid | input | 1 | Read word valid |
| rd_data | input | 16 | Read word |
| adc_reset | output | 1 | Converter reset |
| adc_convst | output | 1 | Conversion start |
| os_sel | output | 3 | Oversampling select pins |
| range_pin | output | 1 | Range select pin |
| stby_n | output | 1 | Standby, active low |
| rd_strobe | output | 1 | Read word request |
| frame_data | output | 128 | Captured frame, 16 bits per channel |
| frame_done | output | 1 | Frame complete pulse |
| frame_err | output | 1 | Frame error pulse |

## Verification
The bench drives a misaligned first word with alignment checking on. A design that missed this would publish the bad frame or keep reading words. It drives the same low flag with checking off, where a design that over-checks would reject good data. The bench also holds busy high to force the timeout, and it issues invalid oversampling ratios and range values. A wrong design would hang, or would move the pins to a bogus code. The standby tests record the cycle of every pin change, so a design that lowers standby before raising range, or skips the reset on exit, gets caught. They also show that writes and requests made during standby leave no trace.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [3:0] {
    ST_RST, ST_IDLE, ST_BUSY, ST_RD, ST_WAIT, ST_DONE,
    ST_SB1, ST_SB2, ST_STBY, ST_WK1, ST_WK2
  } seq_st_t;

  // words per frame for a channel-mode code
  function automatic int chan_count(logic [1:0] mode, int nmax);
    case (mode)
      2'b00:   return nmax;
      2'b01:   return (nmax * 3) / 4;
      default: return nmax / 2;
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_pulse.sv
module adc_seq_pulse #(
  parameter int LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (fire) begin
      cnt   <= CW'(LEN);
      pulse <= 1'b1;
    end else if (cnt > CW'(1)) begin
      cnt <= cnt - CW'(1);
    end else if (cnt == CW'(1)) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg #(
  parameter int OS_LEVELS = 7,
  parameter int RW        = 14,
  parameter int LO_MV     = 5000,
  parameter int HI_MV     = 10000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         accept,
  input  logic                         os_wr,
  input  logic [OS_LEVELS-1:0]         os_ratio,
  input  logic                         range_wr,
  input  logic [RW-1:0]                range_mv,
  input  logic                         force_hi,
  output logic [$clog2(OS_LEVELS)-1:0] os_sel,
  output logic                         range_pin
);
  localparam int SW = $clog2(OS_LEVELS);

  logic          hi_range;
  logic          os_ok;
  logic [SW-1:0] os_code;

  always_comb begin
    os_ok   = 1'b0;
    os_code = '0;
    for (int i = 0; i < OS_LEVELS; i++) begin
      if (os_ratio == OS_LEVELS'(1 << i)) begin
        os_ok   = 1'b1;
        os_code = SW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      os_sel    <= '0;
      hi_range  <= 1'b0;
      range_pin <= 1'b0;
    end else begin
      if (accept && os_wr && os_ok)
        os_sel <= os_code;
      if (accept && range_wr && range_mv == RW'(HI_MV))
        hi_range <= 1'b1;
      else if (accept && range_wr && range_mv == RW'(LO_MV))
        hi_range <= 1'b0;
      range_pin <= force_hi | hi_range;
    end
  end
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int NCH = 8,
  parameter int SW  = 16,
  parameter int IW  = 3,
  parameter int CW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [SW-1:0]     wr_data,
  input  logic              publish,
  input  logic [CW-1:0]     nch,
  output logic [NCH*SW-1:0] frame_data
);
  logic [SW-1:0] hold [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) hold[c] <= '0;
      frame_data <= '0;
    end else begin
      if (wr_en) hold[wr_idx] <= wr_data;
      if (publish) begin
        for (int c = 0; c < NCH; c++)
          frame_data[c*SW +: SW] <= (c < int'(nch)) ? hold[c] : '0;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int SW      = 16,
  parameter int RST_CYC = 10,
  parameter int TMO_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_req,
  input  logic [1:0]        ch_mode,
  input  logic              align_en,
  input  logic              os_wr,
  input  logic [6:0]        os_ratio,
  input  logic              range_wr,
  input  logic [13:0]       range_mv,
  input  logic              stby_enter,
  input  logic              stby_exit,
  input  logic              adc_busy,
  input  logic              adc_frst,
  input  logic              rd_valid,
  input  logic [SW-1:0]     rd_data,
  output logic              adc_reset,
  output logic              adc_convst,
  output logic [2:0]        os_sel,
  output logic              range_pin,
  output logic              stby_n,
  output logic              rd_strobe,
  output logic [NCH*SW-1:0] frame_data,
  output logic              frame_done,
  output logic              frame_err
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CW = $clog2(NCH + 1);
  localparam int TW = $clog2(TMO_CYC + 1);

  seq_st_t       st;
  logic [IW-1:0] idx;
  logic [CW-1:0] nch;
  logic [TW-1:0] tmo;
  logic          busy_q;
  logic          rst_fire;
  logic          range_force;
  logic          wr_en;
  logic          publish;
  logic          accept;

  assign wr_en   = (st == ST_WAIT) && rd_valid;
  assign publish = (st == ST_DONE);
  assign accept  = (st == ST_IDLE);

  adc_seq_pulse #(.LEN(RST_CYC)) u_pulse (
    .clk(clk), .rst(rst), .fire(rst_fire), .pulse(adc_reset)
  );

  adc_seq_cfg #(.OS_LEVELS(7), .RW(14), .LO_MV(5000), .HI_MV(10000)) u_cfg (
    .clk(clk), .rst(rst), .accept(accept),
    .os_wr(os_wr), .os_ratio(os_ratio),
    .range_wr(range_wr), .range_mv(range_mv),
    .force_hi(range_force), .os_sel(os_sel), .range_pin(range_pin)
  );

  adc_seq_capture #(.NCH(NCH), .SW(SW), .IW(IW), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx), .wr_data(rd_data),
    .publish(publish), .nch(nch), .frame_data(frame_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RST;
      rst_fire    <= 1'b1;
      adc_convst  <= 1'b0;
      stby_n      <= 1'b1;
      rd_strobe   <= 1'b0;
      frame_done  <= 1'b0;
      frame_err   <= 1'b0;
      idx         <= '0;
      nch         <= '0;
      tmo         <= '0;
      busy_q      <= 1'b0;
      range_force <= 1'b0;
    end else begin
      rst_fire   <= 1'b0;
      rd_strobe  <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      busy_q     <= adc_busy;
      case (st)
        ST_RST: if (!rst_fire && !adc_reset) st <= ST_IDLE;
        ST_IDLE: begin
          if (stby_enter) begin
            range_force <= 1'b1;
            st          <= ST_SB1;
          end else if (conv_req) begin
            adc_convst <= 1'b1;
            nch        <= CW'(chan_count(ch_mode, NCH));
            tmo        <= '0;
            st         <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (busy_q && !adc_busy) begin
            idx <= '0;
            st  <= ST_RD;
          end else if (tmo == TW'(TMO_CYC - 1)) begin
            adc_convst <= 1'b0;
            frame_err  <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            tmo <= tmo + TW'(1);
          end
        end
        ST_RD: begin
          rd_strobe <= 1'b1;
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_valid) begin
            if (align_en && idx == '0 && !adc_frst) begin
              frame_err  <= 1'b1;
              adc_convst <= 1'b0;
              rst_fire   <= 1'b1;
              st         <= ST_RST;
            end else if (int'(idx) == int'(nch) - 1) begin
              st <= ST_DONE;
            end else begin
              idx <= idx + IW'(1);
              st  <= ST_RD;
            end
          end
        end
        ST_DONE: begin
          frame_done <= 1'b1;
          adc_convst <= 1'b0;
          st         <= ST_IDLE;
        end
        ST_SB1: st <= ST_SB2;
        ST_SB2: begin
          stby_n <= 1'b0;
          st     <= ST_STBY;
        end
        ST_STBY: begin
          if (stby_exit) begin
            range_force <= 1'b0;
            st          <= ST_WK1;
          end
        end
        ST_WK1: st <= ST_WK2;
        ST_WK2: begin
          stby_n   <= 1'b1;
          rst_fire <= 1'b1;
          st       <= ST_RST;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RST_CYC = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       adc_reset,
  input logic       adc_convst,
  input logic [2:0] os_sel,
  input logic       range_pin,
  input logic       stby_n,
  input logic       rd_strobe,
  input logic       frame_done,
  input logic       frame_err
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (adc_reset) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
    else hi_cnt <= '0;
  end

  assert_reset_width_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_reset) |-> (hi_cnt == 16'(RST_CYC)));

  assert_no_read_idle_R3: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> adc_convst);

  assert_convst_low_end_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_done || frame_err) |-> !adc_convst);

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_done, frame_err}));

  assert_os_code_R9: assert property (@(posedge clk) disable iff (rst)
    os_sel != 3'd7);

  assert_range_before_stby_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(stby_n) |-> range_pin);

  assert_reset_after_wake_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(stby_n) |=> adc_reset);

  assert_no_conv_standby_R13: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_convst) |-> stby_n);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst(rst), .adc_reset(adc_reset), .adc_convst(adc_convst),
  .os_sel(os_sel), .range_pin(range_pin), .stby_n(stby_n),
  .rd_strobe(rd_strobe), .frame_done(frame_done), .frame_err(frame_err)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int NCH = 8;
  localparam int SW  = 16;
  localparam int RC  = 10;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_req = 0, align_en = 0, os_wr = 0, range_wr = 0;
  logic stby_enter = 0, stby_exit = 0, adc_busy = 0, adc_frst = 0, rd_valid = 0;
  logic [1:0]  ch_mode = 0;
  logic [6:0]  os_ratio = 0;
  logic [13:0] range_mv = 0;
  logic [SW-1:0] rd_data = 0;
  logic adc_reset, adc_convst, range_pin, stby_n, rd_strobe, frame_done, frame_err;
  logic [2:0] os_sel;
  logic [NCH*SW-1:0] frame_data;

  int checks = 0, errors = 0;
  bit fin = 0;
  logic [SW-1:0] words [NCH];
  int nread, strobes;
  logic got_done, got_err;
  int exp_os;
  logic exp_rng;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.NCH(NCH), .SW(SW), .RST_CYC(RC), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .conv_req(conv_req), .ch_mode(ch_mode), .align_en(align_en),
    .os_wr(os_wr), .os_ratio(os_ratio), .range_wr(range_wr), .range_mv(range_mv),
    .stby_enter(stby_enter), .stby_exit(stby_exit), .adc_busy(adc_busy),
    .adc_frst(adc_frst), .rd_valid(rd_valid), .rd_data(rd_data),
    .adc_reset(adc_reset), .adc_convst(adc_convst), .os_sel(os_sel),
    .range_pin(range_pin), .stby_n(stby_n), .rd_strobe(rd_strobe),
    .frame_data(frame_data), .frame_done(frame_done), .frame_err(frame_err)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int words_for(logic [1:0] m);
    if (m == 2'b00) return NCH;
    if (m == 2'b01) return NCH * 3 / 4;
    return NCH / 2;
  endfunction

  function automatic int os_code(int r);
    for (int i = 0; i < 7; i++) if (r == (1 << i)) return i;
    return -1;
  endfunction

  task automatic measure_reset(string req);
    int cnt = 0;
    for (int i = 0; i < 60 && !adc_reset; i++) tick;
    while (adc_reset && cnt < 200) begin
      cnt++;
      tick;
    end
    check(req, cnt, RC);
    repeat (2) tick;
  endtask

  task automatic run_frame(logic [1:0] mode, logic al, logic frst_ok, int blen);
    ch_mode  = mode;
    align_en = al;
    for (int k = 0; k < NCH; k++) words[k] = SW'($urandom);
    conv_req = 1;
    tick;
    conv_req = 0;
    tick;
    check("R3 convst raised", adc_convst, 1);
    adc_busy = 1;
    strobes  = 0;
    for (int i = 0; i < blen; i++) begin
      tick;
      if (rd_strobe) strobes++;
    end
    check("R3 no read before busy falls", strobes, 0);
    adc_busy = 0;
    nread = 0;
    for (int i = 0; i < 400; i++) begin
      tick;
      rd_valid = 0;
      if (frame_done || frame_err) break;
      if (rd_strobe) begin
        rd_valid = 1;
        rd_data  = words[nread % NCH];
        adc_frst = (nread == 0) ? frst_ok : 1'b0;
        nread++;
      end
    end
    got_done = frame_done;
    got_err  = frame_err;
    rd_valid = 0;
    check("R8 convst low at end", adc_convst, 0);
  endtask

  task automatic check_frame(logic [1:0] mode);
    int n = words_for(mode);
    check("R4 done pulse", got_done, 1);
    check("R4 words read", nread, n);
    for (int k = 0; k < NCH; k++)
      check("R5 R4 channel word", int'(frame_data[k*SW +: SW]),
            (k < n) ? int'(words[k]) : 0);
  endtask

  task automatic write_os(int r);
    os_ratio = 7'(r);
    os_wr = 1;
    tick;
    os_wr = 0;
    tick;
    if (os_code(r) >= 0) exp_os = os_code(r);
    check("R9 os select", os_sel, exp_os);
  endtask

  task automatic write_rng(int mv);
    range_mv = 14'(mv);
    range_wr = 1;
    tick;
    range_wr = 0;
    tick;
    if (mv == 10000) exp_rng = 1;
    else if (mv == 5000) exp_rng = 0;
    check("R10 range pin", range_pin, exp_rng);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NCH*SW-1:0] prev;
    int ri, si;
    void'($urandom(32'h5EED_0606));
    exp_os = 0;
    exp_rng = 0;
    repeat (3) tick;
    check("R1 convst at reset", adc_convst, 0);
    check("R1 stby_n at reset", stby_n, 1);
    check("R1 os_sel at reset", os_sel, 0);
    check("R1 range at reset", range_pin, 0);
    rst = 0;
    tick;
    measure_reset("R1 R2 reset pulse after rst");

    // directed frames in each mode
    run_frame(2'b00, 0, 1, 3); check_frame(2'b00);
    run_frame(2'b01, 0, 1, 2); check_frame(2'b01);
    run_frame(2'b10, 1, 1, 4); check_frame(2'b10);
    run_frame(2'b11, 0, 1, 2); check_frame(2'b11);
    // negative samples
    run_frame(2'b00, 1, 1, 2);
    check_frame(2'b00);

    // misaligned: flag ignored when check disabled
    run_frame(2'b01, 0, 0, 2);
    check("R6 flag ignored when off", got_err, 0);
    check_frame(2'b01);

    // misaligned with check enabled
    prev = frame_data;
    run_frame(2'b00, 1, 0, 3);
    check("R6 error pulse", got_err, 1);
    check("R6 no done", got_done, 0);
    check("R6 one word read", nread, 1);
    check("R6 frame kept", int'(frame_data == prev), 1);
    measure_reset("R6 R2 reset after misalign");

    // timeout
    conv_req = 1; tick; conv_req = 0;
    adc_busy = 1;
    strobes = 0;
    got_err = 0;
    for (int i = 0; i < 3 * TMO && !got_err; i++) begin
      tick;
      if (rd_strobe) strobes++;
      if (frame_err) got_err = 1;
    end
    check("R7 timeout error", got_err, 1);
    check("R7 no reads", strobes, 0);
    check("R8 convst low after timeout", adc_convst, 0);
    adc_busy = 0;
    tick;

    // configuration corners
    write_os(64); write_os(1); write_os(3); write_os(0); write_os(16); write_os(127);
    write_rng(10000); write_rng(7500); write_rng(5000); write_rng(0); write_rng(10000);
    write_rng(5000);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int pick = $urandom_range(0, 2);
      if (pick == 0) begin
        int r = ($urandom_range(0, 1) == 1) ? (1 << $urandom_range(0, 6)) : $urandom_range(0, 127);
        write_os(r);
      end else if (pick == 1) begin
        int sel = $urandom_range(0, 2);
        write_rng(sel == 0 ? 5000 : (sel == 1 ? 10000 : $urandom_range(0, 16383)));
      end else begin
        logic [1:0] m = 2'($urandom_range(0, 3));
        run_frame(m, 1'($urandom_range(0, 1)), 1, $urandom_range(1, 6));
        check_frame(m);
      end
    end

    // standby entry with stored range low
    write_rng(5000);
    ri = -1; si = -1;
    stby_enter = 1; tick; stby_enter = 0;
    for (int i = 0; i < 20; i++) begin
      if (range_pin && ri < 0) ri = i;
      if (!stby_n && si < 0) si = i;
      tick;
    end
    check("R11 standby reached", stby_n, 0);
    check("R11 range before standby", int'(ri >= 0 && si > ri), 1);

    // requests in standby
    strobes = 0;
    conv_req = 1; tick; conv_req = 0;
    ri = 0;
    for (int i = 0; i < 20; i++) begin
      tick;
      if (adc_convst) ri = 1;
      if (rd_strobe) strobes++;
    end
    check("R13 conv ignored in standby", ri, 0);
    check("R13 no reads in standby", strobes, 0);
    os_ratio = 7'd32; os_wr = 1; tick; os_wr = 0; tick;
    check("R13 os write ignored", os_sel, exp_os);
    range_mv = 14'd10000; range_wr = 1; tick; range_wr = 0; tick;

    // standby exit
    ri = -1; si = -1;
    stby_exit = 1; tick; stby_exit = 0;
    for (int i = 0; i < 8; i++) begin
      if (!range_pin && ri < 0) ri = i;
      if (stby_n && si < 0) si = i;
      if (adc_reset) break;
      tick;
    end
    check("R12 R13 range restored first", int'(ri >= 0 && si > ri), 1);
    check("R12 standby released", stby_n, 1);
    measure_reset("R12 R2 reset after wake");
    check("R13 range write ignored", range_pin, 0);

    run_frame(2'b10, 1, 1, 2);
    check_frame(2'b10);

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule